// File: doc/BRIEF.md
# Fixed-Priority Interrupt Arbiter with Stack Hold-Off

This block gathers interrupt requests from four sources of a small microcontroller core: an external pin, a PWM-driven D/A converter and two timer/event counters. Each source has a latched pending flag and an enable bit. One global enable gates all servicing. Software reaches these bits through two byte-wide control registers on a simple write/read bus. When the global enable is set, an enabled source is pending and the hardware stack has room, the block offers an interrupt to the core. The offer carries the fixed vector address of the winning source. The core decides when it takes the offer. At that point it saves its program counter and upper address bits on its own stack, which lies outside this block.

Taking an interrupt clears the global enable, so service routines do not nest by default. Requests that arrive meanwhile are still latched. Software can set the global enable again inside a routine to allow nesting. A wake output leaves the halted state whenever an enabled source is pending. It does not depend on the global enable or on the stack.

The offer to the core is a valid/ready pair. `take_valid` with `take_vector` is the offer, and `take_ready` is the core accepting it at an instruction boundary. A transfer happens on a clock edge where both are high. The offer is a control condition, not a queued item, so it may drop without a transfer. This happens when the stack becomes full, when software clears the global enable or the enable bit, or when software clears the flag. While the offer stands, `take_vector` can change if a higher-priority source becomes pending. The core must latch the vector in the same cycle in which it raises `take_ready`.

Top module: `irq_ctl`

## Requirements
- R1: After reset every flag, enable and the global enable are 0. `take_valid` and `wake` are 0, and both control registers read 0.
- R2: A high `irq_req[i]` at a clock edge sets pending flag i. This happens even while the global enable or the source's enable is 0, and the flag stays set until it is cleared.
- R3: `take_valid` is high exactly when the global enable is 1, at least one source has both its flag and its enable set, and `stack_full` is 0.
- R4: Among the pending enabled sources, the lowest index wins. `take_vector` is 4*(i+1), which gives 0x04, 0x08, 0x0C and 0x10 for sources 0 to 3.
- R5: A transfer (`take_valid` and `take_ready` high at an edge) clears the flag of the winning source and the global enable. If software writes the global enable in the same cycle, the transfer wins.
- R6: While `stack_full` is 1 no offer is made and `take_ready` has no effect. Flags are kept, and the offer returns once `stack_full` falls.
- R7: `wake` is high exactly when some source has both its flag and its enable set, whatever the global enable and `stack_full` are.
- R8: The register at address 0x0B holds the global enable in bit 0, the enables of sources 0 and 1 in bits 1 and 2, and the flags of sources 0 and 1 in bits 4 and 5. The register at address 0x1E holds the enables of sources 2 and 3 in bits 1 and 2 and their flags in bits 4 and 5. All other bits read 0 and ignore writes, and writes to any other address change nothing.
- R9: A bus write loads the enable and flag bits of its register. A hardware request in the same cycle wins, and that flag ends up set.
- R10: After a transfer, software can write the global enable back to 1. The next pending enabled source is then offered at once, which allows nesting.
- R11: If a transfer and a new request of the winning source happen in the same cycle, that source's flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 4 | Request pulses, one per source |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| stack_full | input | 1 | Core's hardware stack has no free entry |
| take_valid | output | 1 | Interrupt offered to the core |
| take_ready | input | 1 | Core accepts the offer this cycle |
| take_vector | output | 8 | Vector address of the offered source |
| wake | output | 1 | Leave halt: an enabled request is pending |

## Verification
Some rules hold on every cycle and the assertions check them there. No offer is made while the stack is full or the global enable is clear. Every offer comes with a wake. A request is latched on the next edge. Every transfer leaves the global enable cleared. The bench scenarios cover the rest. They check the priority choice and vector value against every flag, enable and global-enable combination. They also check the register bit layout and its dead bits, the write-versus-request and transfer-versus-request collisions, the hold-off and recovery around a full stack, and the re-enabling of nesting after a transfer.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int NSRC      = 4;
  localparam int PER_REG   = 2;
  localparam int NREG      = NSRC / PER_REG;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int GLOB_BIT  = 0;
  localparam int EN_LSB    = 1;
  localparam int FLAG_LSB  = 4;
  localparam logic [ADDR_W-1:0] ADDR_LO = 8'h0B;
  localparam logic [ADDR_W-1:0] ADDR_HI = 8'h1E;

  typedef logic [NSRC-1:0] src_vec_t;

  function automatic logic [ADDR_W-1:0] reg_addr(input int r);
    return (r == 0) ? ADDR_LO : ADDR_HI;
  endfunction

  function automatic logic [DATA_W-1:0] live_mask(input int r);
    logic [DATA_W-1:0] m;
    m = '0;
    if (r == 0) m[GLOB_BIT] = 1'b1;
    for (int k = 0; k < PER_REG; k++) begin
      m[EN_LSB + k]   = 1'b1;
      m[FLAG_LSB + k] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/ic_decode.sv
module ic_decode
  import irq_ctl_pkg::*;
(
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NREG-1:0]   hit,
  output logic [NREG-1:0]   wr
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    assign hit[r] = (bus_addr == reg_addr(r));
    assign wr[r]  = bus_we && hit[r];
  end
endmodule

// File: rtl/ic_src_cell.sv
module ic_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic irq,
  input  logic sw_we,
  input  logic sw_en,
  input  logic sw_flag,
  input  logic ack_clr,
  output logic en,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (sw_we) en <= sw_en;
      if (irq)          flag <= 1'b1;
      else if (ack_clr) flag <= 1'b0;
      else if (sw_we)   flag <= sw_flag;
    end
  end

  assert_req_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> flag);
  assert_req_beats_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && ack_clr) |=> flag);
endmodule

// File: rtl/ic_prio.sv
module ic_prio #(
  parameter int N      = 4,
  parameter int VEC_W  = 8,
  parameter int STRIDE = 4
) (
  input  logic [N-1:0]     pend,
  output logic [N-1:0]     grant,
  output logic             any,
  output logic [VEC_W-1:0] vector
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  logic [IDX_W-1:0] idx;

  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && !any) begin
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
        any      = 1'b1;
      end
    end
    vector = VEC_W'((int'(idx) + 1) * STRIDE);
  end
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
  import irq_ctl_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              stack_full,
  output logic              take_valid,
  input  logic              take_ready,
  output logic [VEC_W-1:0]  take_vector,
  output logic              wake
);
  logic [NREG-1:0] hit, wr;
  src_vec_t en, flag, pend, grant;
  logic any_pend, glob_en, fire;
  logic [DATA_W-1:0] used_mask;
  logic unused_wdata;

  ic_decode u_dec (
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .hit     (hit),
    .wr      (wr)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam int R = i / PER_REG;
    localparam int K = i % PER_REG;
    ic_src_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .irq    (irq_req[i]),
      .sw_we  (wr[R]),
      .sw_en  (bus_wdata[EN_LSB + K]),
      .sw_flag(bus_wdata[FLAG_LSB + K]),
      .ack_clr(fire && grant[i]),
      .en     (en[i]),
      .flag   (flag[i])
    );
  end

  assign pend = flag & en;

  ic_prio #(.N(NSRC), .VEC_W(VEC_W), .STRIDE(STRIDE)) u_prio (
    .pend  (pend),
    .grant (grant),
    .any   (any_pend),
    .vector(take_vector)
  );

  assign take_valid = glob_en && any_pend && !stack_full;
  assign fire       = take_valid && take_ready;
  assign wake       = any_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     glob_en <= 1'b0;
    else if (fire)  glob_en <= 1'b0;
    else if (wr[0]) glob_en <= bus_wdata[GLOB_BIT];
  end

  always_comb begin
    bus_rdata = '0;
    used_mask = '0;
    for (int r = 0; r < NREG; r++) begin
      used_mask = used_mask | live_mask(r);
      if (hit[r]) begin
        if (r == 0) bus_rdata[GLOB_BIT] = glob_en;
        for (int k = 0; k < PER_REG; k++) begin
          bus_rdata[EN_LSB + k]   = en[r*PER_REG + k];
          bus_rdata[FLAG_LSB + k] = flag[r*PER_REG + k];
        end
      end
    end
  end
  assign unused_wdata = ^(bus_wdata & ~used_mask);

  assert_no_offer_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stack_full |-> !take_valid);
  assert_offer_needs_glob_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> glob_en);
  assert_take_clears_glob_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && take_ready) |=> !glob_en);
  assert_offer_wakes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> wake);
endmodule

// File: tb/irq_ctl_bench.sv
module irq_ctl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] irq_req = '0;
  logic bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic stack_full = 1'b0;
  logic take_valid;
  logic take_ready = 1'b0;
  logic [7:0] take_vector;
  logic wake;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctl u_irq_ctl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .stack_full(stack_full),
    .take_valid(take_valid), .take_ready(take_ready),
    .take_vector(take_vector), .wake(wake)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] lo_val(input logic g, input logic [3:0] e, input logic [3:0] f);
    return {2'b00, f[1:0], 1'b0, e[1:0], g};
  endfunction
  function automatic logic [7:0] hi_val(input logic [3:0] e, input logic [3:0] f);
    return {2'b00, f[3:2], 1'b0, e[3:2], 1'b0};
  endfunction
  function automatic int exp_vec(input logic [3:0] p);
    for (int i = 0; i < 4; i++) if (p[i]) return (i + 1) * 4;
    return 0;
  endfunction

  // drive at a falling edge, the register updates at the following rising edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask
  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    #1 check("R1 valid", take_valid, 0);
    check("R1 wake", wake, 0);
    rd(8'h0B, d); check("R1 lo", d, 0);
    rd(8'h1E, d); check("R1 hi", d, 0);
    rst_n = 1'b1;

    // R3 R4 R7 sweep over global enable, enables and flags
    for (int g = 0; g < 2; g++) begin
      for (int e = 0; e < 16; e++) begin
        for (int f = 0; f < 16; f++) begin
          logic [3:0] p;
          p = 4'(e) & 4'(f);
          wr(8'h1E, hi_val(4'(e), 4'(f)));
          wr(8'h0B, lo_val(g[0], 4'(e), 4'(f)));
          #1;
          check("R3 offer", take_valid, (g == 1 && p != 0) ? 1 : 0);
          check("R7 wake", wake, (p != 0) ? 1 : 0);
          if (p != 0) check("R4 vector", take_vector, exp_vec(p));
          rd(8'h0B, d); check("R8 lo readback", d, lo_val(g[0], 4'(e), 4'(f)));
          rd(8'h1E, d); check("R8 hi readback", d, hi_val(4'(e), 4'(f)));
        end
      end
    end

    // R8 dead bits and foreign address
    wr(8'h0B, 8'hFF); rd(8'h0B, d); check("R8 lo mask", d, 8'h37);
    wr(8'h1E, 8'hFF); rd(8'h1E, d); check("R8 hi mask", d, 8'h36);
    wr(8'h0C, 8'h00); rd(8'h0B, d); check("R8 other addr lo", d, 8'h37);
    rd(8'h1E, d); check("R8 other addr hi", d, 8'h36);
    rd(8'h0C, d); check("R8 other addr read", d, 0);

    // R2 latch with everything disabled
    wr(8'h0B, 8'h00); wr(8'h1E, 8'h00);
    @(negedge clk); irq_req = 4'b1001;
    @(negedge clk); irq_req = 4'b0000;
    rd(8'h0B, d); check("R2 flag0 latched", d, 8'h10);
    rd(8'h1E, d); check("R2 flag3 latched", d, 8'h20);
    check("R2 no offer", take_valid, 0);
    check("R7 no wake disabled", wake, 0);

    // R5 transfer: enable 0 and 3 plus global
    wr(8'h1E, 8'h24); wr(8'h0B, 8'h13);
    #1 check("R4 vec src0", take_vector, 8'h04);
    @(negedge clk); take_ready = 1'b1; bus_we = 1'b1; bus_addr = 8'h0B; bus_wdata = 8'h13;
    @(negedge clk); take_ready = 1'b0; bus_we = 1'b0;
    rd(8'h0B, d); check("R5 flag0 and glob cleared", d, 8'h02);
    check("R5 no offer after", take_valid, 0);
    check("R7 wake src3", wake, 1);

    // R10 re-enable nests to source 3
    wr(8'h0B, 8'h03);
    #1 check("R10 offer again", take_valid, 1);
    check("R10 vector src3", take_vector, 8'h10);

    // R6 full stack holds off
    @(negedge clk); stack_full = 1'b1;
    #1 check("R6 offer held", take_valid, 0);
    check("R6 wake stays", wake, 1);
    take_ready = 1'b1;
    @(negedge clk); take_ready = 1'b0;
    rd(8'h1E, d); check("R6 flag kept", d, 8'h24);
    rd(8'h0B, d); check("R6 glob kept", d, 8'h03);
    stack_full = 1'b0;
    #1 check("R6 offer returns", take_valid, 1);

    // R11 transfer with same-source request
    @(negedge clk); take_ready = 1'b1; irq_req = 4'b1000;
    @(negedge clk); take_ready = 1'b0; irq_req = 4'b0000;
    rd(8'h1E, d); check("R11 flag3 kept", d, 8'h24);
    rd(8'h0B, d); check("R11 glob cleared", d, 8'h02);

    // R9 write clear collides with request
    @(negedge clk); bus_we = 1'b1; bus_addr = 8'h1E; bus_wdata = 8'h06; irq_req = 4'b0100;
    @(negedge clk); bus_we = 1'b0; irq_req = 4'b0000;
    rd(8'h1E, d); check("R9 request wins", d, 8'h16);
    wr(8'h1E, 8'h06); rd(8'h1E, d); check("R9 write clears", d, 8'h06);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule